// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause-22 management transactions (register reads and writes) towards external PHY devices over a two-wire management bus. Software drives it through one 32-bit command/status word. That word carries the PHY address, the PHY register address, the operation request and a 16-bit data field. The block builds the serial frame. It derives the management clock from the system clock, drives or releases the data line, and collects the returned bits on a read. When the frame is over it sets a completion flag.

A typical sequence is as follows. Software clears the completion flag with a write-one-to-clear. It then writes a word with a read or write request bit set, and polls the word until the flag reads one. After a read, the PHY's answer is found in the upper half of the same word, in the place where write data was given. Only one transaction can be in flight. A word written while the bus is busy is dropped.

Top module: `mdio_master`

## Requirements
- R1: After reset the command/status word reads 0x0000_0000, mdc is low, mdio_oe is low and mdio_o is high.
- R2: Word layout: bits 4:0 hold the PHY address, bits 12:8 the register address, bit 13 a write request, bit 14 a read request, bit 15 the completion flag, bits 31:16 the data; bits 7:5 read as zero. A write with bit 13 or 14 set while idle starts a transaction. In the next cycle the word reads back the new fields, the data field and the request bit of the operation, with bit 15 low.
- R3: A write frame is 32 ones, then 01, then opcode 01, then the PHY address and the register address (MSB first), then turnaround 10, then the 16 data bits MSB first. mdio_oe is high for all 64 bit times.
- R4: A read frame carries opcode 10. mdio_oe is low from the first turnaround bit (bit time 46) through the last bit. The 16 bits present on mdio_i at the MDC rising edges of bit times 48 to 63 are written, MSB first, to bits 31:16 at completion.
- R5: While a transaction runs, MDC stays high for exactly HALF_DIV clock cycles and low for exactly HALF_DIV clock cycles. Each frame has exactly 64 rising edges, and mdc stays low when idle. The default HALF_DIV of 50 gives 2.5 MHz from a 250 MHz clock.
- R6: mdio_o changes only on the clock edge where mdc falls.
- R7: The completion flag reads 1 exactly 128*HALF_DIV cycles after the start edge, and not one cycle earlier. Bits 14 and 13 read 0 from that point on.
- R8: A write with bit 15 set and no request bit clears the completion flag and leaves every other field unchanged. A write with bits 15, 14 and 13 all zero changes nothing.
- R9: A word written while a transaction is in progress is ignored. The readback, the frame on the wire and the result are unaffected, and no second transaction follows.
- R10: A word with both request bits set performs a read.
- R11: Starting a transaction clears a completion flag that was left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the command/status word |
| reg_wdata | input | 32 | Value written to the command/status word |
| reg_rdata | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Management data driven out |
| mdio_oe | output | 1 | High while the block drives the data line |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
The busy readback is due one cycle after the write strobe is taken. The bench samples it at the falling clock edge right after that strobe. Completion is due exactly 128*HALF_DIV cycles after the start edge, so each transaction samples the word at the falling clock edge one cycle before that point and again at the point itself, which pins the flag to a single cycle. Frame content and driver enable are recorded at every MDC rising edge and compared against a frame the bench builds from the command. The PHY model changes mdio_i only right after an MDC rise, which leaves the next sample a full bit time to settle. MDC half-periods and the instants where mdio_o changes are timed against the clock throughout the run.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    // Field widths of the management frame
    localparam int PHY_W  = 5;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;

    // Start, opcode, two addresses and turnaround
    localparam int HDR_BITS = 2 + 2 + PHY_W + REG_W + 2;

    // Positions inside the command/status word (software decodes these)
    localparam int F_PHY_LSB  = 0;
    localparam int F_REG_LSB  = 8;
    localparam int F_WR_BIT   = 13;
    localparam int F_RD_BIT   = 14;
    localparam int F_DONE_BIT = 15;
    localparam int F_DATA_LSB = 16;

    // Command handed to the frame engine at the start edge
    typedef struct packed {
        logic [PHY_W-1:0]  phy;
        logic [REG_W-1:0]  regad;
        logic [DATA_W-1:0] wdata;
        logic              is_read;
    } mdio_cmd_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);

    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_t;

    div_t div_d, div_q;
    logic wrap;

    assign wrap = run && (div_q.cnt == CNT_LAST);

    always_comb begin
        div_d = div_q;
        if (start) begin
            div_d.cnt = '0;
            div_d.mdc = 1'b0;
        end else if (!run) begin
            div_d = '0;
        end else if (wrap) begin
            div_d.cnt = '0;
            div_d.mdc = !div_q.mdc;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign mdc       = div_q.mdc;
    assign rise_tick = wrap && !div_q.mdc;
    assign fall_tick = wrap && div_q.mdc;

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
#(
    parameter int PREAMBLE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_cmd_t         cmd_in,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              xfer_done,
    output logic [DATA_W-1:0] rx_data
);

    localparam int FRAME_LEN = PREAMBLE_LEN + HDR_BITS + DATA_W;
    localparam int BW        = $clog2(FRAME_LEN);
    localparam int TA_POS    = PREAMBLE_LEN + HDR_BITS - 2;
    localparam int DAT_POS   = PREAMBLE_LEN + HDR_BITS;
    localparam logic [BW-1:0] LAST_IDX = BW'(FRAME_LEN - 1);
    localparam logic [BW-1:0] TA_IDX   = BW'(TA_POS);
    localparam logic [BW-1:0] DAT_IDX  = BW'(DAT_POS);

    typedef struct packed {
        logic                 active;
        logic                 rd;
        logic [BW-1:0]        bit_idx;
        logic [FRAME_LEN-1:0] sh;
        logic [FRAME_LEN-1:0] oe;
        logic [DATA_W-1:0]    rx;
    } frm_t;

    frm_t frm_d, frm_q;
    logic [FRAME_LEN-1:0] line_vec;
    logic [FRAME_LEN-1:0] drive_vec;
    logic                 done_c;

    // Whole frame is laid out once at the start edge, first bit at the MSB
    always_comb begin
        line_vec = {{PREAMBLE_LEN{1'b1}}, 2'b01,
                    (cmd_in.is_read ? 2'b10 : 2'b01),
                    cmd_in.phy, cmd_in.regad,
                    (cmd_in.is_read ? 2'b11 : 2'b10),
                    (cmd_in.is_read ? {DATA_W{1'b1}} : cmd_in.wdata)};
        if (cmd_in.is_read)
            drive_vec = {{TA_POS{1'b1}}, {(FRAME_LEN - TA_POS){1'b0}}};
        else
            drive_vec = '1;
    end

    always_comb begin
        frm_d  = frm_q;
        done_c = 1'b0;
        if (start) begin
            frm_d.active  = 1'b1;
            frm_d.rd      = cmd_in.is_read;
            frm_d.bit_idx = '0;
            frm_d.sh      = line_vec;
            frm_d.oe      = drive_vec;
            frm_d.rx      = '0;
        end else if (frm_q.active) begin
            // PHY data is taken on the MDC rising edge
            if (rise_tick && frm_q.rd && (frm_q.bit_idx >= DAT_IDX))
                frm_d.rx = {frm_q.rx[DATA_W-2:0], mdio_i};
            // Line moves to the next bit on the MDC falling edge
            if (fall_tick) begin
                frm_d.sh = {frm_q.sh[FRAME_LEN-2:0], 1'b1};
                frm_d.oe = {frm_q.oe[FRAME_LEN-2:0], 1'b0};
                if (frm_q.bit_idx == LAST_IDX) begin
                    frm_d.active = 1'b0;
                    done_c       = 1'b1;
                end else begin
                    frm_d.bit_idx = frm_q.bit_idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q        <= '0;
            frm_q.sh     <= '1;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign mdio_o    = frm_q.sh[FRAME_LEN-1];
    assign mdio_oe   = frm_q.oe[FRAME_LEN-1];
    assign xfer_done = done_c;
    assign rx_data   = frm_q.rx;

    // R4: line released from turnaround to the end of a read
    a_r4_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q.active && frm_q.rd && (frm_q.bit_idx >= TA_IDX)) |-> !mdio_oe);

    // R3: a write frame keeps the line driven throughout
    a_r3_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q.active && !frm_q.rd) |-> mdio_oe);

endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] rx_data,
    output logic              start,
    output mdio_cmd_t         cmd_next,
    output logic              busy,
    output logic [31:0]       reg_rdata
);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              rd;
        logic              wr;
        logic [PHY_W-1:0]  phy;
        logic [REG_W-1:0]  regad;
        logic [DATA_W-1:0] data;
    } creg_t;

    creg_t cr_d, cr_q;
    logic  req;
    logic  unused_gap;

    assign unused_gap = ^reg_wdata[F_REG_LSB-1:F_PHY_LSB+PHY_W];

    always_comb begin
        req              = reg_wdata[F_RD_BIT] | reg_wdata[F_WR_BIT];
        cmd_next.phy     = reg_wdata[F_PHY_LSB +: PHY_W];
        cmd_next.regad   = reg_wdata[F_REG_LSB +: REG_W];
        cmd_next.wdata   = reg_wdata[F_DATA_LSB +: DATA_W];
        cmd_next.is_read = reg_wdata[F_RD_BIT];
    end

    always_comb begin
        cr_d  = cr_q;
        start = 1'b0;
        if (cr_q.busy) begin
            // Writes arriving here are dropped on purpose
            if (xfer_done) begin
                cr_d.busy = 1'b0;
                cr_d.done = 1'b1;
                cr_d.rd   = 1'b0;
                cr_d.wr   = 1'b0;
                if (cr_q.rd) cr_d.data = rx_data;
            end
        end else if (reg_wr) begin
            if (reg_wdata[F_DONE_BIT]) cr_d.done = 1'b0;
            if (req) begin
                start      = 1'b1;
                cr_d.busy  = 1'b1;
                cr_d.done  = 1'b0;
                cr_d.rd    = cmd_next.is_read;
                cr_d.wr    = !cmd_next.is_read;
                cr_d.phy   = cmd_next.phy;
                cr_d.regad = cmd_next.regad;
                cr_d.data  = cmd_next.wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cr_q <= '0;
        else        cr_q <= cr_d;
    end

    always_comb begin
        reg_rdata                           = '0;
        reg_rdata[F_PHY_LSB +: PHY_W]       = cr_q.phy;
        reg_rdata[F_REG_LSB +: REG_W]       = cr_q.regad;
        reg_rdata[F_WR_BIT]                 = cr_q.wr;
        reg_rdata[F_RD_BIT]                 = cr_q.rd;
        reg_rdata[F_DONE_BIT]               = cr_q.done;
        reg_rdata[F_DATA_LSB +: DATA_W]     = cr_q.data;
    end

    assign busy = cr_q.busy;

    // R7: the flag only rises as a transaction ends
    a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cr_q.done) |-> $fell(cr_q.busy));

    // R8: clear-only write drops the flag and keeps the data field
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (!cr_q.busy && reg_wr && reg_wdata[F_DONE_BIT] && !req)
        |=> (!cr_q.done && $stable(cr_q.data)));

    // R9: addresses hold while a write arrives during a transaction
    a_r9_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_q.busy && reg_wr) |=> ($stable(cr_q.phy) && $stable(cr_q.regad)));

    // R10: both request bits give a read
    a_r10_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (start && reg_wdata[F_RD_BIT] && reg_wdata[F_WR_BIT]) |=> (cr_q.rd && !cr_q.wr));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV     = 50,
    parameter int PREAMBLE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    localparam int HW = ((HALF_DIV > 1) ? $clog2(HALF_DIV) : 1) + 2;
    localparam logic [HW-1:0] HOLD_LAST = HW'(HALF_DIV - 1);

    logic              start;
    logic              busy;
    logic              xfer_done;
    logic              rise_tick;
    logic              fall_tick;
    mdio_cmd_t         cmd_next;
    logic [DATA_W-1:0] rx_data;

    mdio_cmd_reg u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .xfer_done (xfer_done),
        .rx_data   (rx_data),
        .start     (start),
        .cmd_next  (cmd_next),
        .busy      (busy),
        .reg_rdata (reg_rdata)
    );

    mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .run       (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_in    (cmd_next),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .xfer_done (xfer_done),
        .rx_data   (rx_data)
    );

    // Independent phase timer: cycles since mdc last moved or a run began
    logic          mdc_prev_q;
    logic          busy_prev_q;
    logic [HW-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_prev_q  <= 1'b0;
            busy_prev_q <= 1'b0;
            hold_q      <= '0;
        end else begin
            mdc_prev_q  <= mdc;
            busy_prev_q <= busy;
            if ((mdc != mdc_prev_q) || (busy && !busy_prev_q))
                hold_q <= '0;
            else if (hold_q != '1)
                hold_q <= hold_q + 1'b1;
        end
    end

    // R5: every MDC level lasts HALF_DIV cycles
    a_r5_mdc_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc != mdc_prev_q) |-> (hold_q == HOLD_LAST));

    // R6: the data line moves only with a falling MDC
    a_r6_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc));

    // R5: MDC idles low
    a_r5_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$fell(busy)) |-> !mdc);

endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;

    localparam int H      = 4;
    localparam int CLK_NS = 4;
    localparam int NBITS  = 64;
    localparam int TX     = 2 * NBITS * H;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mdio_master #(.HALF_DIV(H)) i_mdio_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    // PHY model and line recorder
    int          rise_cnt = 0;
    logic [15:0] phy_val  = 16'h0;
    logic [63:0] rec_o, rec_oe;
    time         t_rise = 0;
    int          err_mdc = 0;
    int          err_chg = 0;

    assign mdio_i = (rise_cnt >= 48 && rise_cnt < 64) ? phy_val[63 - rise_cnt] : 1'b1;

    always @(posedge mdc) begin
        if (rise_cnt > 0 && ($time - t_rise) != 2 * H * CLK_NS) err_mdc++;
        t_rise = $time;
        if (rise_cnt < 64) begin
            rec_o[63 - rise_cnt]  = mdio_o;
            rec_oe[63 - rise_cnt] = mdio_oe;
        end
        rise_cnt++;
    end

    always @(negedge mdc) begin
        if (($time - t_rise) != H * CLK_NS) err_mdc++;
    end

    logic prev_o = 1'b1, prev_mdc = 1'b0;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (mdio_o !== prev_o && !(prev_mdc === 1'b1 && mdc === 1'b0)) err_chg++;
        end
        prev_o   = mdio_o;
        prev_mdc = mdc;
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] line_of(input bit rd, input logic [4:0] phy,
                                            input logic [4:0] ra, input logic [15:0] dat);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra,
                (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : dat)};
    endfunction

    function automatic logic [63:0] oe_of(input bit rd);
        return rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    endfunction

    // Drive one word; returns at the falling edge after the capturing edge
    task automatic put(input logic [31:0] w, input bit starts);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = w;
        if (starts) rise_cnt = 0;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic finish_frame(input string req, input int already,
                                input logic [31:0] final_exp,
                                input logic [63:0] line_exp, input logic [63:0] oe_exp);
        repeat (TX - 1 - already) @(negedge clk);
        chk("R7", "flag one cycle early", {63'b0, reg_rdata[15]}, 64'd0);
        @(negedge clk);
        chk(req, "word at completion", {32'b0, reg_rdata}, {32'b0, final_exp});
        chk(req, "line bits", rec_o, line_exp);
        chk(req, "drive enable", rec_oe, oe_exp);
        chk("R5", "rising edges per frame", rise_cnt, 64'd64);
    endtask

    task automatic t_reset();
        chk("R1", "word after reset", {32'b0, reg_rdata}, 64'd0);
        chk("R1", "pins {mdc,oe,o}", {61'b0, mdc, mdio_oe, mdio_o}, 64'd1);
    endtask

    task automatic t_write();
        put(32'hA5C3_2511, 1'b1);
        chk("R2", "readback while busy", {32'b0, reg_rdata}, {32'b0, 32'hA5C3_2511});
        finish_frame("R3", 0, 32'hA5C3_8511,
                     line_of(1'b0, 5'h11, 5'h05, 16'hA5C3), oe_of(1'b0));
    endtask

    task automatic t_clear();
        put(32'h0000_0000, 1'b0);
        chk("R8", "all-zero write", {32'b0, reg_rdata}, {32'b0, 32'hA5C3_8511});
        put(32'h1234_8000, 1'b0);
        chk("R8", "clear-only write", {32'b0, reg_rdata}, {32'b0, 32'hA5C3_0511});
        chk("R5", "mdc idle after clear", {63'b0, mdc}, 64'd0);
    endtask

    task automatic t_read_busy();
        phy_val = 16'h5A96;
        put(32'h0000_5F03, 1'b1);
        chk("R2", "read readback while busy", {32'b0, reg_rdata}, {32'b0, 32'h0000_5F03});
        repeat (50) @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = 32'hBEEF_A507;
        @(negedge clk);
        reg_wr    = 1'b0;
        chk("R9", "write during transaction", {32'b0, reg_rdata}, {32'b0, 32'h0000_5F03});
        finish_frame("R4", 51, 32'h5A96_9F03,
                     line_of(1'b1, 5'h03, 5'h1F, 16'h0), oe_of(1'b1));
        repeat (4 * H) @(negedge clk);
        chk("R9", "no second frame", {31'b0, mdc, rise_cnt[31:0]}, 64'd64);
    endtask

    task automatic t_both_ops();
        phy_val = 16'hC00F;
        put(32'hFFFF_6A1C, 1'b1);
        chk("R11", "flag cleared by start", {63'b0, reg_rdata[15]}, 64'd0);
        chk("R10", "read chosen", {32'b0, reg_rdata}, {32'b0, 32'hFFFF_4A1C});
        finish_frame("R10", 0, 32'hC00F_8A1C,
                     line_of(1'b1, 5'h1C, 5'h0A, 16'h0), oe_of(1'b1));
    endtask

    task automatic t_timing();
        chk("R5", "mdc half-period errors", err_mdc, 64'd0);
        chk("R6", "mdio_o moves off mdc fall", err_chg, 64'd0);
    endtask

    initial begin
        rst_n     = 1'b0;
        reg_wr    = 1'b0;
        reg_wdata = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_clear();
        t_read_busy();
        t_both_ops();
        t_timing();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule